// File: doc/BRIEF.md
# Shift Register Upset Test Controller

This block runs radiation exposure tests on a long serial chain of flip-flops. It generates the chain's serial data input and a slow, gated shift clock from the system clock. It samples the chain's serial output and compares every sampled bit with a locally regenerated copy of the test pattern. Mismatches are counted in a saturating counter, and the bit positions of the earliest mismatches are kept in a small log.

The block has two run modes. In store mode the chain is filled with a train of clock pulses, left completely unclocked for a programmable number of system cycles, then emptied and checked. This sequence repeats for a programmable number of passes, and completed passes are counted so that errors can be related to the write/read traffic. In streaming mode the clock runs without a break. Each shift pushes a new pattern bit in and checks the bit that comes out. The first chain-length outputs are skipped because they only carry the pipeline fill. A chain that is flagged as made of dynamic cells cannot hold data without a clock, so store-mode requests for such a chain are refused.

Top module: `seu_chain_tester`

## Requirements
- R1: A store pass issues exactly `chain_len` rising edges of `chain_sclk` to load, then `chain_len` more to unload. Loaded bit k is the k-th bit driven on `chain_sdi`, and it is compared as the k-th unloaded sample.
- R2: Between loading and unloading, `chain_sclk` stays low for `hold_cycles`+1 system cycles, with no rising edge.
- R3: In streaming mode, `stream_shifts` clock pulses are issued. Each pulse pushes pattern bit s. The first `chain_len` samples are not compared. Every later sample is compared with the bit pushed `chain_len` shifts earlier.
- R4: `pat_sel` encodes the pattern bit at index k. 2'b00 gives alternating with bit 0 = 1. 2'b01 gives all zeros. 2'b10 gives all ones. 2'b11 gives alternating with bit 0 = 0.
- R5: The shift clock period is 2·`div_half` system cycles, with the clock high for the second half. A `div_half` of 0 behaves as 1.
- R6: A start request is refused in three cases: store mode on a chain flagged dynamic, `chain_len` of 0, or `chain_len` above MAX_LEN. A refused request issues no clock pulse, leaves `busy` and `done` low, and sets `rejected` until the next accepted start.
- R7: Each mismatch adds one to `err_count`. The count saturates at all ones and is cleared by an accepted start.
- R8: Store mode repeats the load/hold/unload pass `store_passes` times, with 0 treated as 1. `pass_count` counts completed unloads in the current run.
- R9: The first LOG_DEPTH mismatches of a run are logged with their bit index, readable through `log_rd_idx`/`log_rd_pos`. `log_fill` gives the number of entries. A store entry is the unload index. A streaming entry is the index of the pattern bit that was pushed.
- R10: An accepted start clears `done` and raises `busy`. `done` rises with `busy` falling once the last comparison is finished. A start pulse while busy is ignored.
- R11: After reset, `busy`, `done`, `rejected`, `chain_sclk`, `err_count`, `pass_count` and `log_fill` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle run request |
| mode_stream | input | 1 | 1: streaming mode, 0: store mode |
| chain_dynamic | input | 1 | Chain under test uses dynamic cells |
| pat_sel | input | 2 | Test pattern select |
| chain_len | input | LEN_W | Number of cells in the chain |
| div_half | input | DIV_W | Half shift-clock period in system cycles |
| hold_cycles | input | HOLD_W | Unclocked hold length |
| store_passes | input | PASS_W | Store passes per run |
| stream_shifts | input | RUN_W | Shift pulses in a streaming run |
| chain_sdo | input | 1 | Serial output of the chain |
| chain_sdi | output | 1 | Serial input of the chain |
| chain_sclk | output | 1 | Gated shift clock of the chain |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| rejected | output | 1 | Last request refused |
| err_count | output | ERR_W | Saturating mismatch count |
| pass_count | output | PASS_W | Completed store passes |
| log_rd_idx | input | IDX_W | Log entry to read |
| log_rd_pos | output | POS_W | Bit index held in that entry |
| log_fill | output | FILL_W | Valid log entries |

## Verification
On every shift tick, the block samples the chain output and drives the next input bit in the same system cycle. A mismatch on the very first sample of a pass therefore coincides with the first new drive. The bench provokes this by flipping the chain's last cell during the hold. It then checks that exactly one error is logged at index 0 and that the data later loaded is unaffected. In streaming mode, a cell is flipped right after a known shift edge. The bench computes the index of the corrupted bit from the edge count and cell position, and compares it with the logged position. A second start pulse in the middle of the run must leave the pulse total unchanged.

// File: rtl/seu_tst_pkg.sv
package seu_tst_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LOAD   = 3'd1,
      ST_HOLD   = 3'd2,
      ST_UNLOAD = 3'd3,
      ST_STREAM = 3'd4
   } tst_state_e;

   // pattern codes (R4)
   localparam logic [1:0] PAT_ALT10 = 2'b00;
   localparam logic [1:0] PAT_ZERO  = 2'b01;
   localparam logic [1:0] PAT_ONE   = 2'b10;
   localparam logic [1:0] PAT_ALT01 = 2'b11;

   function automatic logic pat_bit(input logic [1:0] sel, input logic idx_odd);
      logic b;
      case (sel)
         PAT_ALT10: b = ~idx_odd;
         PAT_ZERO:  b = 1'b0;
         PAT_ONE:   b = 1'b1;
         default:   b = idx_odd;
      endcase
      return b;
   endfunction

endpackage

// File: rtl/seu_tick_div.sv
module seu_tick_div #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] half,
   output logic             tick_lo,
   output logic             tick_hi
);
   logic [DIV_W-1:0] half_eff;
   logic [DIV_W:0]   cnt;
   logic [DIV_W:0]   wrap_at;

   // a zero half period is taken as one (R5)
   assign half_eff = (half == '0) ? DIV_W'(1) : half;
   assign wrap_at  = {half_eff, 1'b0} - (DIV_W+1)'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!en)            cnt <= '0;
      else if (cnt == wrap_at) cnt <= '0;
      else                     cnt <= cnt + (DIV_W+1)'(1);
   end

   assign tick_lo = en && (cnt == '0);
   assign tick_hi = en && (cnt == {1'b0, half_eff});
endmodule

// File: rtl/seu_err_log.sv
module seu_err_log #(
   parameter int ERR_W     = 32,
   parameter int LOG_DEPTH = 16,
   parameter int POS_W     = 24,
   parameter int IDX_W     = 4,
   parameter int FILL_W    = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              hit,
   input  logic [POS_W-1:0]  hit_pos,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [ERR_W-1:0]  err_count,
   output logic [POS_W-1:0]  rd_pos,
   output logic [FILL_W-1:0] fill
);
   // saturating mismatch counter (R7)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       err_count <= '0;
      else if (clear)                   err_count <= '0;
      else if (hit && err_count != '1)  err_count <= err_count + ERR_W'(1);
   end

   generate
      if (LOG_DEPTH > 0) begin : g_log
         logic [POS_W-1:0]  mem [LOG_DEPTH];
         logic [FILL_W-1:0] cnt;
         logic              wr;

         assign wr = hit && !clear && (cnt < FILL_W'(LOG_DEPTH));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt <= '0;
            else if (clear) cnt <= '0;
            else if (wr)    cnt <= cnt + FILL_W'(1);
         end

         always_ff @(posedge clk) begin
            if (wr) mem[cnt[IDX_W-1:0]] <= hit_pos;
         end

         assign rd_pos = ({1'b0, rd_idx} < (IDX_W+1)'(LOG_DEPTH)) ? mem[rd_idx] : '0;
         assign fill   = cnt;
      end else begin : g_nolog
         assign rd_pos = '0;
         assign fill   = '0;
      end
   endgenerate
endmodule

// File: rtl/seu_chain_tester.sv
module seu_chain_tester
   import seu_tst_pkg::*;
#(
   parameter int MAX_LEN   = 2048,
   parameter int DIV_W     = 8,
   parameter int HOLD_W    = 24,
   parameter int PASS_W    = 8,
   parameter int RUN_W     = 24,
   parameter int ERR_W     = 32,
   parameter int LOG_DEPTH = 16,
   localparam int LEN_W    = $clog2(MAX_LEN + 1),
   localparam int POS_W    = (RUN_W > LEN_W) ? RUN_W : LEN_W,
   localparam int IDX_W    = (LOG_DEPTH > 1) ? $clog2(LOG_DEPTH) : 1,
   localparam int FILL_W   = $clog2(LOG_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_stream,
   input  logic              chain_dynamic,
   input  logic [1:0]        pat_sel,
   input  logic [LEN_W-1:0]  chain_len,
   input  logic [DIV_W-1:0]  div_half,
   input  logic [HOLD_W-1:0] hold_cycles,
   input  logic [PASS_W-1:0] store_passes,
   input  logic [RUN_W-1:0]  stream_shifts,
   input  logic              chain_sdo,
   output logic              chain_sdi,
   output logic              chain_sclk,
   output logic              busy,
   output logic              done,
   output logic              rejected,
   output logic [ERR_W-1:0]  err_count,
   output logic [PASS_W-1:0] pass_count,
   input  logic [IDX_W-1:0]  log_rd_idx,
   output logic [POS_W-1:0]  log_rd_pos,
   output logic [FILL_W-1:0] log_fill
);
   generate
      if (MAX_LEN < 2)   begin : g_chk_len  $error("MAX_LEN must be at least 2");   end
      if (DIV_W < 1)     begin : g_chk_div  $error("DIV_W must be positive");       end
      if (ERR_W < 2)     begin : g_chk_err  $error("ERR_W must be at least 2");     end
      if (LOG_DEPTH < 0) begin : g_chk_log  $error("LOG_DEPTH cannot be negative"); end
   endgenerate

   tst_state_e        state;
   logic [POS_W-1:0]  slot;
   logic [HOLD_W-1:0] hold_cnt;
   logic [PASS_W-1:0] pass_cnt;

   logic              r_stream;
   logic [1:0]        r_pat;
   logic [LEN_W-1:0]  r_len;
   logic [DIV_W-1:0]  r_half;
   logic [HOLD_W-1:0] r_hold;
   logic [PASS_W-1:0] r_passes;
   logic [RUN_W-1:0]  r_shifts;

   logic              bad_req, go;
   logic              tick_en, tick_lo, tick_hi;
   logic [POS_W-1:0]  len_ext, limit, hit_pos;
   logic              slot_end, cmp_en, exp_bit, drive_bit, hit, last_pass;

   // request screening (R6)
   assign bad_req = (chain_len == '0) || (chain_len > LEN_W'(MAX_LEN)) ||
                    (!mode_stream && chain_dynamic);
   assign go      = (state == ST_IDLE) && start && !bad_req;

   assign len_ext  = POS_W'(r_len);
   assign limit    = r_stream ? POS_W'(r_shifts) : len_ext;
   assign slot_end = (slot == limit);
   assign tick_en  = (state == ST_LOAD) || (state == ST_UNLOAD) || (state == ST_STREAM);

   // comparison: store compares every unload slot, stream skips fill (R1, R3)
   assign cmp_en    = tick_lo && !slot_end &&
                      ((state == ST_UNLOAD) || ((state == ST_STREAM) && (slot >= len_ext)));
   assign exp_bit   = pat_bit(r_pat, (state == ST_STREAM) ? (slot[0] ^ r_len[0]) : slot[0]);
   assign hit       = cmp_en && (chain_sdo != exp_bit);
   assign hit_pos   = (state == ST_STREAM) ? (slot - len_ext) : slot;
   assign drive_bit = (state == ST_UNLOAD) ? 1'b0 : pat_bit(r_pat, slot[0]);
   assign last_pass = ({1'b0, pass_cnt} + (PASS_W+1)'(1)) >= {1'b0, r_passes};

   seu_tick_div #(.DIV_W(DIV_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (tick_en),
      .half    (r_half),
      .tick_lo (tick_lo),
      .tick_hi (tick_hi)
   );

   seu_err_log #(
      .ERR_W(ERR_W), .LOG_DEPTH(LOG_DEPTH), .POS_W(POS_W), .IDX_W(IDX_W), .FILL_W(FILL_W)
   ) u_log (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (go),
      .hit       (hit),
      .hit_pos   (hit_pos),
      .rd_idx    (log_rd_idx),
      .err_count (err_count),
      .rd_pos    (log_rd_pos),
      .fill      (log_fill)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         slot       <= '0;
         hold_cnt   <= '0;
         pass_cnt   <= '0;
         chain_sclk <= 1'b0;
         chain_sdi  <= 1'b0;
         busy       <= 1'b0;
         done       <= 1'b0;
         rejected   <= 1'b0;
         r_stream   <= 1'b0;
         r_pat      <= '0;
         r_len      <= '0;
         r_half     <= '0;
         r_hold     <= '0;
         r_passes   <= '0;
         r_shifts   <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  if (bad_req) begin
                     rejected <= 1'b1;
                     done     <= 1'b0;
                  end else begin
                     r_stream <= mode_stream;
                     r_pat    <= pat_sel;
                     r_len    <= chain_len;
                     r_half   <= div_half;
                     r_hold   <= hold_cycles;
                     r_passes <= store_passes;
                     r_shifts <= stream_shifts;
                     busy     <= 1'b1;
                     done     <= 1'b0;
                     rejected <= 1'b0;
                     slot     <= '0;
                     pass_cnt <= '0;
                     state    <= mode_stream ? ST_STREAM : ST_LOAD;
                  end
               end
            end
            ST_HOLD: begin
               // clock parked low for hold_cycles+1 cycles (R2)
               if (hold_cnt == r_hold) begin
                  slot  <= '0;
                  state <= ST_UNLOAD;
               end else begin
                  hold_cnt <= hold_cnt + HOLD_W'(1);
               end
            end
            default: begin
               if (tick_lo) begin
                  chain_sclk <= 1'b0;
                  if (!slot_end) begin
                     chain_sdi <= drive_bit;
                  end else begin
                     case (state)
                        ST_LOAD: begin
                           hold_cnt <= '0;
                           state    <= ST_HOLD;
                        end
                        ST_UNLOAD: begin
                           pass_cnt <= pass_cnt + PASS_W'(1);
                           if (last_pass) begin
                              busy  <= 1'b0;
                              done  <= 1'b1;
                              state <= ST_IDLE;
                           end else begin
                              // next pass: the first bit is put out now,
                              // as the divider does not restart (R8)
                              slot      <= '0;
                              chain_sdi <= pat_bit(r_pat, 1'b0);
                              state     <= ST_LOAD;
                           end
                        end
                        default: begin
                           busy  <= 1'b0;
                           done  <= 1'b1;
                           state <= ST_IDLE;
                        end
                     endcase
                  end
               end else if (tick_hi) begin
                  chain_sclk <= 1'b1;
                  slot       <= slot + POS_W'(1);
               end
            end
         endcase
      end
   end

   assign pass_count = pass_cnt;
endmodule

// File: rtl/seu_chain_tester_chk.sv
module seu_chain_tester_chk
   import seu_tst_pkg::*;
#(
   parameter int ERR_W     = 32,
   parameter int FILL_W    = 5,
   parameter int POS_W     = 24,
   parameter int LOG_DEPTH = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              mode_stream,
   input logic              chain_dynamic,
   input logic              chain_sclk,
   input logic              busy,
   input logic              done,
   input logic              rejected,
   input logic [ERR_W-1:0]  err_count,
   input logic [FILL_W-1:0] log_fill,
   input tst_state_e        state,
   input logic              go,
   input logic              hit,
   input logic [POS_W-1:0]  slot,
   input logic [POS_W-1:0]  len_ext
);
   p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_HOLD) |-> !chain_sclk);

   p_fill_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_STREAM) && (slot < len_ext)) |-> !hit);

   p_dyn_refused_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_IDLE) && start && !mode_stream && chain_dynamic) |=> (rejected && !busy));

   p_err_no_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> (err_count >= $past(err_count)));

   p_log_grow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && (log_fill < FILL_W'(LOG_DEPTH))) |=> (log_fill == $past(log_fill) + FILL_W'(1)));

   p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_go_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (busy && !done));
endmodule

bind seu_chain_tester seu_chain_tester_chk #(
   .ERR_W(ERR_W), .FILL_W(FILL_W), .POS_W(POS_W), .LOG_DEPTH(LOG_DEPTH)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .start         (start),
   .mode_stream   (mode_stream),
   .chain_dynamic (chain_dynamic),
   .chain_sclk    (chain_sclk),
   .busy          (busy),
   .done          (done),
   .rejected      (rejected),
   .err_count     (err_count),
   .log_fill      (log_fill),
   .state         (state),
   .go            (go),
   .hit           (hit),
   .slot          (slot),
   .len_ext       (len_ext)
);

// File: tb/seu_chain_tester_bench.sv
module seu_chain_tester_bench;
   localparam int CLK_P     = 10;
   localparam int MAX_LEN   = 16;
   localparam int DIV_W     = 4;
   localparam int HOLD_W    = 8;
   localparam int PASS_W    = 4;
   localparam int RUN_W     = 8;
   localparam int ERR_W     = 4;
   localparam int LOG_DEPTH = 4;
   localparam int LEN_W     = $clog2(MAX_LEN + 1);
   localparam int POS_W     = (RUN_W > LEN_W) ? RUN_W : LEN_W;
   localparam int IDX_W     = 2;
   localparam int FILL_W    = $clog2(LOG_DEPTH + 1);

   logic clk = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic              mode_stream = 1'b0;
   logic              chain_dynamic = 1'b0;
   logic [1:0]        pat_sel = 2'b00;
   logic [LEN_W-1:0]  chain_len = LEN_W'(8);
   logic [DIV_W-1:0]  div_half = DIV_W'(2);
   logic [HOLD_W-1:0] hold_cycles = '0;
   logic [PASS_W-1:0] store_passes = PASS_W'(1);
   logic [RUN_W-1:0]  stream_shifts = '0;
   logic              chain_sdo;
   logic              chain_sdi, chain_sclk, busy, done, rejected;
   logic [ERR_W-1:0]  err_count;
   logic [PASS_W-1:0] pass_count;
   logic [IDX_W-1:0]  log_rd_idx = '0;
   logic [POS_W-1:0]  log_rd_pos;
   logic [FILL_W-1:0] log_fill;

   seu_chain_tester #(
      .MAX_LEN(MAX_LEN), .DIV_W(DIV_W), .HOLD_W(HOLD_W), .PASS_W(PASS_W),
      .RUN_W(RUN_W), .ERR_W(ERR_W), .LOG_DEPTH(LOG_DEPTH)
   ) u_seu_chain_tester (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_stream(mode_stream),
      .chain_dynamic(chain_dynamic), .pat_sel(pat_sel), .chain_len(chain_len),
      .div_half(div_half), .hold_cycles(hold_cycles), .store_passes(store_passes),
      .stream_shifts(stream_shifts), .chain_sdo(chain_sdo), .chain_sdi(chain_sdi),
      .chain_sclk(chain_sclk), .busy(busy), .done(done), .rejected(rejected),
      .err_count(err_count), .pass_count(pass_count), .log_rd_idx(log_rd_idx),
      .log_rd_pos(log_rd_pos), .log_fill(log_fill)
   );

   // behavioural chain under test with injectable flips
   logic [15:0] q = '0;
   int tb_len = 8;
   int edges = 0;
   always @(posedge chain_sclk) begin
      q = {q[14:0], chain_sdi};
      edges++;
   end
   always_comb chain_sdo = q[tb_len-1];

   int checks = 0;
   int errors = 0;

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_len(input int n);
      tb_len    = (n < 1) ? 1 : n;
      chain_len = LEN_W'(n);
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_edges(input int n);
      int k = 0;
      while (edges < n && k < 20000) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic wait_done();
      int k = 0;
      while (!done && k < 20000) begin
         @(negedge clk);
         k++;
      end
      if (!done) chk("R10 run never finished", 0, 1);
   endtask

   task automatic read_log(input int idx, output int pos);
      log_rd_idx = IDX_W'(idx);
      #1;
      pos = int'(log_rd_pos);
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int e0, pos;
      longint t1, t2;

      // R11 reset state
      repeat (3) @(negedge clk);
      chk("R11 busy at reset", busy, 0);
      chk("R11 done at reset", done, 0);
      chk("R11 sclk at reset", chain_sclk, 0);
      chk("R11 err at reset", err_count, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 rejected after reset", rejected, 0);
      chk("R11 pass after reset", pass_count, 0);
      chk("R11 fill after reset", log_fill, 0);

      // store mode, clean, two passes, alternating 1-0
      set_len(8); div_half = 2; hold_cycles = 20; store_passes = 2; pat_sel = 2'b00;
      mode_stream = 0; chain_dynamic = 0; edges = 0;
      pulse_start();
      chk("R10 busy after start", busy, 1);
      chk("R10 done cleared at start", done, 0);
      wait_edges(8);
      repeat (4) @(negedge clk);
      chk("R4 alt10 chain image after load", q[7:0], 8'hAA);
      e0 = edges;
      repeat (10) @(negedge clk);
      chk("R2 no clock during hold", edges, e0);
      wait_done();
      chk("R1 pulses per store run", edges, 32);
      chk("R8 passes completed", pass_count, 2);
      chk("R7 clean store errors", err_count, 0);
      chk("R10 busy low at done", busy, 0);

      // all ones, two flips in hold
      pat_sel = 2'b10; hold_cycles = 10; store_passes = 1; edges = 0;
      pulse_start();
      wait_edges(8);
      repeat (4) @(negedge clk);
      q[0] = ~q[0];
      q[5] = ~q[5];
      wait_done();
      chk("R1 two flips counted", err_count, 2);
      chk("R9 log fill two", log_fill, 2);
      read_log(0, pos); chk("R9 first logged index", pos, 2);
      read_log(1, pos); chk("R9 second logged index", pos, 7);
      chk("R8 single pass", pass_count, 1);

      // odd length, alt 0-1, flip on the last cell (first sample of unload)
      set_len(5); pat_sel = 2'b11; edges = 0;
      pulse_start();
      wait_edges(5);
      repeat (4) @(negedge clk);
      chk("R4 alt01 chain image after load", q[4:0], 5'b01010);
      q[4] = ~q[4];
      wait_done();
      chk("R1 last-cell flip counted once", err_count, 1);
      read_log(0, pos); chk("R9 last-cell flip logged at index 0", pos, 0);

      // full length, all zero, invert whole chain in both holds: saturation
      set_len(16); pat_sel = 2'b01; hold_cycles = 30; store_passes = 2; edges = 0;
      pulse_start();
      wait_edges(16);
      repeat (4) @(negedge clk);
      q = ~q;
      wait_edges(48);
      repeat (4) @(negedge clk);
      q = ~q;
      wait_done();
      chk("R7 error count saturates", err_count, 15);
      chk("R9 log stops at depth", log_fill, 4);
      read_log(3, pos); chk("R9 fourth entry", pos, 3);
      chk("R8 two passes at full length", pass_count, 2);

      // refusals
      set_len(8); chain_dynamic = 1; mode_stream = 0; edges = 0;
      pulse_start();
      repeat (20) @(negedge clk);
      chk("R6 dynamic store refused", rejected, 1);
      chk("R6 no busy on refusal", busy, 0);
      chk("R6 no done on refusal", done, 0);
      chk("R6 no clock on refusal", edges, 0);
      mode_stream = 1; chain_dynamic = 0; set_len(17);
      pulse_start();
      repeat (10) @(negedge clk);
      chk("R6 over-length refused", rejected, 1);
      chain_len = '0;
      pulse_start();
      repeat (10) @(negedge clk);
      chk("R6 zero length refused", rejected, 1);
      chk("R6 still no clock", edges, 0);

      // streaming on a dynamic chain, garbage prefill ignored
      set_len(8); chain_dynamic = 1; mode_stream = 1; div_half = 3;
      stream_shifts = 40; pat_sel = 2'b00; q = '1; edges = 0;
      pulse_start();
      chk("R6 accepted start clears rejected", rejected, 0);
      wait_edges(3);
      t1 = $time;
      wait_edges(4);
      t2 = $time;
      chk("R5 shift period", (t2 - t1) / CLK_P, 6);
      wait_done();
      chk("R3 stream pulse count", edges, 40);
      chk("R3 fill outputs not compared", err_count, 0);

      // streaming flip mid-run; start pulse while busy ignored
      stream_shifts = 60; edges = 0;
      pulse_start();
      wait_edges(10);
      stream_shifts = 5;
      pulse_start();
      wait_edges(20);
      q[3] = ~q[3];
      wait_done();
      chk("R10 start while busy ignored", edges, 60);
      chk("R3 one streaming error", err_count, 1);
      read_log(0, pos); chk("R9 streaming index", pos, 16);

      // zero half period acts as one
      set_len(4); div_half = 0; stream_shifts = 10; edges = 0;
      pulse_start();
      wait_edges(2);
      t1 = $time;
      wait_edges(3);
      t2 = $time;
      chk("R5 zero half period", (t2 - t1) / CLK_P, 2);
      wait_done();
      chk("R3 short stream clean", err_count, 0);
      chk("R3 short stream pulses", edges, 10);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule